// File: doc/BRIEF.md
# Cell-to-SONET Payload Mapper

This block packs fixed-length user cells into a byte-serial STS-48c frame stream, one line byte per clock. Every row of the frame opens with 144 overhead columns. The block copies these from a separate overhead byte input without changing them. The remaining 4176 columns of each row form the payload area. Cells fill this area back to back, starting at the first payload column of the first row. A cell continues across rows and skips the overhead columns of each later row.

On the line, each cell is a delineation header byte, then the user bytes, then a parity byte. A cell is never allowed to run past the end of the frame's payload area. Before each cell, the block compares the payload capacity still left against the full cell length. When the cell no longer fits, it fills the rest of the frame with zero pad bytes.

User cells arrive on a byte-wide valid/ready interface. If no cell is offered at a cell boundary, the block sends an idle cell. A single pulse on `frame_start` aligns the frame. After that pulse the row and column position runs freely from frame to frame.

Top module: `cell_frame_mapper`

## Requirements
- R1: While reset is high, and until the first `frame_start` pulse after reset, `tx_data` is 0x00, `tx_sof` is 0 and `in_ready` is 0.
- R2: `frame_start` marks row 0, column 0. The position then advances one column per clock over 9 rows of 4320 columns and wraps on its own. Every output byte appears one clock after its position cycle. `tx_sof` is high for exactly that one clock for row 0, column 0.
- R3: In columns 0 to 143 of every row, `tx_data` carries the `oh_data` value present in that position cycle.
- R4: The first cell of each frame starts at row 0, column 144. The next cells follow back to back over the payload columns. Each cell is one header byte, then the user bytes, then one parity byte, so it is 2 bytes longer than its user part.
- R5: `cell_sel` sets the user length: 0 gives 75 bytes, 1 gives 79, 2 gives 83 and 3 gives 91. The resulting line cell sizes are 77, 81, 85 and 93 bytes.
- R6: Header byte layout: bits 7:2 hold the pattern 6'b110100, bit 1 is 1 for a user cell and 0 for an idle cell, and bit 0 is set so that the whole byte has an odd number of ones.
- R7: The parity byte is the bitwise XOR of the cell's user bytes, which gives even parity per bit position.
- R8: A cell starts only if the payload bytes left in the frame are at least the line cell size. All later payload bytes of that frame are 0x00 pad. The result is 488, 464, 442 or 404 cells and 8, 0, 14 or 12 pad bytes per frame, for `cell_sel` 0 to 3.
- R9: If `in_valid` is low in the header cycle, the cell is idle. Its header valid bit is 0, its body and parity bytes are 0x00, and it takes no input bytes.
- R10: `in_ready` is high exactly in the body byte cycles of a user cell. Each cycle with `in_valid` and `in_ready` both high moves one byte from `in_data` to the line. A source that offers a cell keeps `in_valid` high until its last byte is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Line byte clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Marks the current cycle as row 0, column 0 |
| oh_data | input | 8 | Overhead byte for the current overhead column |
| cell_sel | input | 2 | Static user cell length select |
| in_valid | input | 1 | User byte or cell offered |
| in_data | input | 8 | User cell byte |
| in_ready | output | 1 | User byte taken this cycle when valid |
| tx_data | output | 8 | Registered line byte |
| tx_sof | output | 1 | Registered marker for the first byte of a frame |

## Verification
On every cycle the assertions check four things: no cell is still open when a frame wraps, the capacity count never runs dry inside a payload column, every header byte has the fixed pattern and odd parity, and an accepted user byte is never followed by a header. The bench scenarios cover the rest, which the assertions cannot show. They check the exact line position of every cell and pad byte, the per-frame cell and pad counts for all four sizes, the parity values, and that idle cells appear when the source holds back. They also check that the overhead bytes pass through unchanged.

// File: rtl/cfm_pkg.sv
package cfm_pkg;

  typedef enum logic [1:0] {
    PH_HDR  = 2'd0,
    PH_BODY = 2'd1,
    PH_BIP  = 2'd2,
    PH_PAD  = 2'd3
  } phase_t;

  // user part length of a cell for each size select code
  function automatic logic [7:0] user_len(input logic [1:0] sel);
    case (sel)
      2'd0:    return 8'd75;
      2'd1:    return 8'd79;
      2'd2:    return 8'd83;
      default: return 8'd91;
    endcase
  endfunction

  // delineation header: pattern, valid flag, odd parity over the byte
  function automatic logic [7:0] make_hdr(input logic [5:0] pat, input logic vld);
    return {pat, vld, ~(^{pat, vld})};
  endfunction

endpackage

// File: rtl/cfm_frame_timer.sv
module cfm_frame_timer #(
  parameter int ROWS     = 9,
  parameter int ROW_COLS = 4320,
  parameter int OH_COLS  = 144
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_start,
  output logic synced,
  output logic frame_top,
  output logic pay_col
);
  localparam int CW = $clog2(ROW_COLS);
  localparam int RW = $clog2(ROWS);
  localparam logic [CW-1:0] LAST_COL = CW'(ROW_COLS - 1);
  localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);
  localparam logic [CW-1:0] OH_END   = CW'(OH_COLS);

  logic [CW-1:0] col_q, col_cur;
  logic [RW-1:0] row_q, row_cur;
  logic          synced_q;

  always_comb begin
    col_cur   = frame_start ? '0 : col_q;
    row_cur   = frame_start ? '0 : row_q;
    synced    = synced_q | frame_start;
    frame_top = synced && (col_cur == '0) && (row_cur == '0);
    pay_col   = synced && (col_cur >= OH_END);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      col_q    <= '0;
      row_q    <= '0;
      synced_q <= 1'b0;
    end else if (synced) begin
      synced_q <= 1'b1;
      if (col_cur == LAST_COL) begin
        col_q <= '0;
        row_q <= (row_cur == LAST_ROW) ? '0 : row_cur + RW'(1);
      end else begin
        col_q <= col_cur + CW'(1);
        row_q <= row_cur;
      end
    end
  end

  AST_COL_RANGE: assert property (@(posedge clk) disable iff (rst)
    (col_q <= LAST_COL) && (row_q <= LAST_ROW)); // R2

endmodule

// File: rtl/cfm_capacity.sv
module cfm_capacity #(
  parameter int CAP_BYTES = 37584,
  parameter int CAP_W     = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_top,
  input  logic             pay_col,
  input  logic [CAP_W-1:0] need,
  output logic             fits
);
  localparam logic [CAP_W-1:0] CAP_FULL = CAP_W'(CAP_BYTES);

  logic [CAP_W-1:0] cap_q;

  assign fits = (cap_q >= need);

  always_ff @(posedge clk) begin
    if (rst)
      cap_q <= CAP_FULL;
    else if (frame_top)
      cap_q <= CAP_FULL;
    else if (pay_col)
      cap_q <= cap_q - CAP_W'(1);
  end

  AST_CAP_NONZERO: assert property (@(posedge clk) disable iff (rst)
    pay_col |-> (cap_q != '0)); // R8

endmodule

// File: rtl/cfm_cell_fsm.sv
module cfm_cell_fsm
  import cfm_pkg::*;
#(
  parameter logic [5:0] HDR_PATTERN = 6'b110100
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       frame_top,
  input  logic       pay_col,
  input  logic       fits,
  input  logic [7:0] ulen,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  output logic [7:0] pay_byte,
  output logic       hdr_emit
);
  phase_t     phase_q, phase_d;
  logic [7:0] cnt_q, cnt_d;
  logic [7:0] bip_q, bip_d;
  logic       vld_q, vld_d;
  logic [7:0] body_byte;

  always_comb begin
    phase_d   = phase_q;
    cnt_d     = cnt_q;
    bip_d     = bip_q;
    vld_d     = vld_q;
    pay_byte  = 8'h00;
    in_ready  = 1'b0;
    hdr_emit  = 1'b0;
    body_byte = (vld_q && in_valid) ? in_data : 8'h00;
    case (phase_q)
      PH_HDR: begin
        if (fits) begin
          pay_byte = make_hdr(HDR_PATTERN, in_valid);
          hdr_emit = pay_col;
          vld_d    = in_valid;
          cnt_d    = '0;
          bip_d    = '0;
          phase_d  = PH_BODY;
        end else begin
          phase_d  = PH_PAD;
        end
      end
      PH_BODY: begin
        in_ready = pay_col && vld_q;
        pay_byte = body_byte;
        bip_d    = bip_q ^ body_byte;
        cnt_d    = cnt_q + 8'd1;
        if (cnt_q == ulen - 8'd1) phase_d = PH_BIP;
      end
      PH_BIP: begin
        pay_byte = bip_q;
        phase_d  = PH_HDR;
      end
      default: pay_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || frame_top) begin
      phase_q <= PH_HDR;
      cnt_q   <= '0;
      bip_q   <= '0;
      vld_q   <= 1'b0;
    end else if (pay_col) begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      bip_q   <= bip_d;
      vld_q   <= vld_d;
    end
  end

  AST_NO_SPAN: assert property (@(posedge clk) disable iff (rst)
    frame_top |-> (phase_q == PH_HDR || phase_q == PH_PAD)); // R8

  AST_BODY_RANGE: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_BODY) |-> (cnt_q < ulen)); // R4

endmodule

// File: rtl/cell_frame_mapper.sv
module cell_frame_mapper
  import cfm_pkg::*;
#(
  parameter int         ROWS        = 9,
  parameter int         ROW_COLS    = 4320,
  parameter int         OH_COLS     = 144,
  parameter logic [5:0] HDR_PATTERN = 6'b110100
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       frame_start,
  input  logic [7:0] oh_data,
  input  logic [1:0] cell_sel,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  output logic [7:0] tx_data,
  output logic       tx_sof
);
  localparam int CAP_BYTES = ROWS * (ROW_COLS - OH_COLS);
  localparam int CAP_W     = $clog2(CAP_BYTES + 1);

  logic             synced, frame_top, pay_col, fits, hdr_emit, hdr_q;
  logic [7:0]       ulen, pay_byte;
  logic [CAP_W-1:0] need;

  assign ulen = user_len(cell_sel);
  assign need = CAP_W'(ulen) + CAP_W'(2);

  cfm_frame_timer #(
    .ROWS(ROWS), .ROW_COLS(ROW_COLS), .OH_COLS(OH_COLS)
  ) u_timer (
    .clk(clk), .rst(rst), .frame_start(frame_start),
    .synced(synced), .frame_top(frame_top), .pay_col(pay_col)
  );

  cfm_capacity #(
    .CAP_BYTES(CAP_BYTES), .CAP_W(CAP_W)
  ) u_cap (
    .clk(clk), .rst(rst), .frame_top(frame_top), .pay_col(pay_col),
    .need(need), .fits(fits)
  );

  cfm_cell_fsm #(
    .HDR_PATTERN(HDR_PATTERN)
  ) u_fsm (
    .clk(clk), .rst(rst), .frame_top(frame_top), .pay_col(pay_col),
    .fits(fits), .ulen(ulen), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .pay_byte(pay_byte), .hdr_emit(hdr_emit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_data <= 8'h00;
      tx_sof  <= 1'b0;
      hdr_q   <= 1'b0;
    end else begin
      tx_sof  <= frame_top;
      hdr_q   <= hdr_emit;
      if (!synced)
        tx_data <= 8'h00;
      else if (pay_col)
        tx_data <= pay_byte;
      else
        tx_data <= oh_data;
    end
  end

  AST_SOF_SINGLE: assert property (@(posedge clk) disable iff (rst)
    tx_sof |=> !tx_sof); // R2

  AST_HDR_PARITY: assert property (@(posedge clk) disable iff (rst)
    hdr_q |-> ((^tx_data) && (tx_data[7:2] == HDR_PATTERN))); // R6

  AST_TAKE_NOT_HDR: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !hdr_q); // R10

endmodule

// File: tb/cell_frame_mapper_test.sv
module cell_frame_mapper_test;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS = 9, ROW_COLS = 4320, OH = 144;
  localparam int PAYW = ROW_COLS - OH;
  localparam int FRAME = ROWS * ROW_COLS;
  localparam int CAP = ROWS * PAYW;
  localparam logic [5:0] PAT = 6'b110100;

  logic clk = 1'b0, rst = 1'b1, frame_start = 1'b0, in_valid = 1'b0;
  logic [7:0] oh_data = 8'h00, in_data = 8'h00;
  logic [1:0] cell_sel = 2'd0;
  logic in_ready, tx_sof;
  logic [7:0] tx_data;

  int checks = 0, errors = 0;
  int unsigned salt;

  always #(CLK_PERIOD/2) clk = ~clk;

  cell_frame_mapper uut (
    .clk(clk), .rst(rst), .frame_start(frame_start), .oh_data(oh_data),
    .cell_sel(cell_sel), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .tx_data(tx_data), .tx_sof(tx_sof)
  );

  function automatic int exp_ulen(input int sel);   // R5
    case (sel) 0: return 75; 1: return 79; 2: return 83; default: return 91; endcase
  endfunction
  function automatic int exp_cells(input int sel);  // R8
    case (sel) 0: return 488; 1: return 464; 2: return 442; default: return 404; endcase
  endfunction
  function automatic int exp_pad(input int sel);    // R8
    case (sel) 0: return 8; 1: return 0; 2: return 14; default: return 12; endcase
  endfunction
  function automatic logic [7:0] exp_hdr(input logic v);  // R6
    logic [7:0] b;
    b = {PAT, v, 1'b0};
    b[0] = ~(^b);
    return b;
  endfunction
  function automatic logic [7:0] cbyte(input int c, input int i);
    int unsigned x;
    x = c * 29 + i * 7 + salt;
    return 8'(x ^ (x >> 9) ^ (c >> 2));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp_v, $time);
    end
  endtask

  task automatic run_size(input int sel, input int start_pct);
    int ulen, tot, ncell, src_cell, src_idx, m_cell, hdr_seen, pad_seen, pend_fp;
    bit holding, acc, have_exp, m_vld, exp_sof, exp_rdy, pend_hdr, pend_pad;
    logic [7:0] exp_tx, m_bip, d;
    string tag;
    ulen = exp_ulen(sel); tot = ulen + 2; ncell = CAP / tot;
    src_cell = 0; src_idx = 0; holding = 0; acc = 0; have_exp = 0;
    m_vld = 0; m_cell = 0; m_bip = 0; hdr_seen = 0; pad_seen = 0;
    pend_fp = -1; pend_hdr = 0; pend_pad = 0; exp_tx = 0; exp_sof = 0; tag = "";
    rst = 1; frame_start = 0; in_valid = 0; cell_sel = 2'(sel);
    repeat (3) @(negedge clk);
    check(tx_data == 8'h00 && tx_sof == 1'b0 && in_ready == 1'b0, "R1 reset", tx_data, 0);
    rst = 0;
    in_valid = 1; in_data = 8'hA5;
    repeat (3) @(negedge clk);
    check(tx_data == 8'h00 && tx_sof == 1'b0, "R1 unsynced out", tx_data, 0);
    check(in_ready == 1'b0, "R1 unsynced ready", in_ready, 0);
    in_valid = 0;
    for (int n = 0; n < FRAME + 300; n++) begin
      int fp, row, col, q, k, off;
      @(negedge clk);
      if (have_exp) begin
        check(tx_data == exp_tx, tag, tx_data, exp_tx);
        check(tx_sof == exp_sof, "R2 sof", tx_sof, exp_sof);
        if (pend_hdr && tx_data[7:2] == PAT) hdr_seen++;
        if (pend_pad && tx_data == 8'h00) pad_seen++;
        if (pend_fp == FRAME - 1) begin
          check(hdr_seen == exp_cells(sel), "R8 cells per frame", hdr_seen, exp_cells(sel));
          check(pad_seen == exp_pad(sel), "R8 pad per frame", pad_seen, exp_pad(sel));
          hdr_seen = 0; pad_seen = 0;
        end
      end
      if (acc) begin
        src_idx++;
        if (src_idx == ulen) begin src_idx = 0; src_cell++; holding = 0; end
      end
      if (!holding && $urandom_range(0, 99) < start_pct) holding = 1;
      in_valid = holding;
      in_data = holding ? cbyte(src_cell, src_idx) : 8'($urandom);
      frame_start = (n == 0);
      oh_data = 8'($urandom);
      fp = n % FRAME; row = fp / ROW_COLS; col = fp % ROW_COLS;
      exp_sof = (fp == 0); exp_rdy = 0; pend_hdr = 0; pend_pad = 0; pend_fp = fp;
      if (col < OH) begin
        exp_tx = oh_data; tag = "R3 overhead";
      end else begin
        q = row * PAYW + col - OH; k = q / tot; off = q % tot;
        if (k >= ncell) begin
          exp_tx = 8'h00; tag = "R8 pad"; pend_pad = 1;
        end else if (off == 0) begin
          m_vld = in_valid; m_cell = src_cell; m_bip = 0;
          exp_tx = exp_hdr(m_vld); tag = "R6 header"; pend_hdr = 1;
        end else if (off <= ulen) begin
          d = m_vld ? cbyte(m_cell, off - 1) : 8'h00;
          exp_rdy = m_vld; m_bip ^= d; exp_tx = d;
          tag = m_vld ? "R4 body" : "R9 idle body";
        end else begin
          exp_tx = m_bip; tag = "R7 parity";
        end
      end
      #1;
      check(in_ready == exp_rdy, "R10 ready", in_ready, exp_rdy);
      acc = in_valid && in_ready;
      have_exp = 1;
    end
    in_valid = 0; frame_start = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 195000);
    errors++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1157));
    salt = $urandom;
    run_size(0, 60);
    run_size(1, 100);
    run_size(2, 4);
    run_size(3, 40);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule